// File: doc/BRIEF.md
# Single-Bit Hamming ECC Corrector

This block checks one chunk of data just read from flash. It takes the 24-bit code calculated over the chunk and the 24-bit code kept in the spare area, and it XORs them into a difference word. From that difference it gives one of three verdicts: clean, corrected or uncorrectable. When the difference points at a single flipped data bit, the block repairs the byte-wide chunk buffer. It reads the addressed byte, XORs in a one-hot mask and writes the byte back.

A separate combinational formatter turns a raw 32-bit parity register into the code that is stored. It keeps two 12-bit fields and inverts them, so an erased (all-ones) spare area matches a zero raw parity. The host pulses `start_i` with both codes valid, then waits for the one-cycle `done_o` pulse and reads `status_o`.

Top module: `hamming_chunk_corrector`

## Requirements
- R1: `packed_code_o` equals the bitwise inverse of {raw bits 27:16, raw bits 11:0}. Raw bits 11:0 fill code bits 11:0, and the least significant stored byte lies in bits 7:0.
- R2: If `calc_code_i` XOR `stored_code_i` is zero, `done_o` pulses in the cycle after `start_i` with status 2'b00 (clean), and the buffer is not accessed.
- R3: If bits 23:12 of the difference are the bitwise complement of bits 11:0, and the byte index (difference bits 23:15) is below CHUNK_BYTES, the block patches the buffer. It reads that byte, writes it back with bit number (difference bits 14:12) inverted and no other bit changed, and reports status 2'b01 (corrected).
- R4: If the halves are complementary but the byte index is not below CHUNK_BYTES, `done_o` pulses in the cycle after `start_i` with status 2'b10 (uncorrectable), and the buffer is not accessed.
- R5: If the difference has exactly one bit set, `done_o` pulses in the cycle after `start_i` with status 2'b01, and the buffer is not accessed.
- R6: Any other nonzero difference gives `done_o` in the cycle after `start_i` with status 2'b10, and no buffer access.
- R7: A patch follows a fixed timing. `buf_rd_en_o` is high for one cycle, the cycle after `start_i`. The buffer returns `buf_rdata_i` one cycle after the read strobe. `buf_wr_en_o` and `done_o` are high together, two cycles after the read strobe. The address is held over both the read and the write.
- R8: While a patch is in progress, `start_i` is ignored: it produces no extra `done_o` and no buffer access. A start in the cycle after the write-back `done_o` is accepted.
- R9: While reset is asserted, `done_o`, `buf_rd_en_o` and `buf_wr_en_o` are low and `status_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_parity_i | input | 32 | Raw parity register value for the formatter |
| packed_code_o | output | 24 | Formatted code to store, least significant byte in bits 7:0 |
| start_i | input | 1 | One-cycle request to check the two codes |
| calc_code_i | input | 24 | Code calculated over the chunk just read |
| stored_code_i | input | 24 | Code read back from the spare area |
| buf_rd_en_o | output | 1 | Buffer read strobe |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 9 | Byte address within the chunk buffer |
| buf_rdata_i | input | 8 | Byte returned by the buffer, one cycle after the read strobe |
| buf_wdata_o | output | 8 | Repaired byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The bench builds the corrector with CHUNK_BYTES set to 384 and keeps the 12-bit half width. The nine-bit index field can then name bytes 384 to 511, which lie beyond the chunk, so the uncorrectable out-of-range case can be reached. With the default chunk of 512 bytes that case cannot occur. The patch path is tested at bytes 0 and 383, at the edge of the chunk, and at bit positions 0 and 7. Starts held across a patch show that the busy window ignores requests until the write-back completes.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b10
  } ecc_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } patch_phase_e;

  typedef struct packed {
    ecc_status_e status;
    logic        patch;
  } verdict_t;

endpackage

// File: rtl/ecc_code_packer.sv
module ecc_code_packer #(
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16,
  parameter int RAW_W  = 32,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);

  // each half of the code comes from its own field of the raw word, inverted
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign code_o[h*HALF_W +: HALF_W] = ~raw_i[h*HI_LSB +: HALF_W];
  end

  logic unused_raw;
  assign unused_raw = ^raw_i;

endmodule

// File: rtl/ecc_diff_judge.sv
module ecc_diff_judge
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int IDX_W  = HALF_W - 3
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output verdict_t          verdict_o,
  output logic [IDX_W-1:0]  byte_o,
  output logic [2:0]        bit_o
);

  localparam int unsigned LIMIT = CHUNK_BYTES;

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] hi_half;
  logic [HALF_W-1:0] lo_half;
  logic              is_zero;
  logic              halves_comp;
  logic              one_hot;
  logic              in_range;

  assign diff        = calc_i ^ stored_i;
  assign hi_half     = diff[CODE_W-1:HALF_W];
  assign lo_half     = diff[HALF_W-1:0];
  assign is_zero     = (diff == '0);
  assign halves_comp = ((hi_half ^ lo_half) == {HALF_W{1'b1}});
  assign one_hot     = !is_zero && ((diff & (diff - CODE_W'(1))) == '0);
  assign byte_o      = diff[CODE_W-1:HALF_W+3];
  assign bit_o       = diff[HALF_W+2:HALF_W];
  assign in_range    = (32'(byte_o) < LIMIT);

  always_comb begin
    verdict_o.patch  = 1'b0;
    verdict_o.status = ST_FAIL;
    if (is_zero) begin
      verdict_o.status = ST_CLEAN;
    end else if (halves_comp) begin
      if (in_range) begin
        verdict_o.patch  = 1'b1;
        verdict_o.status = ST_FIXED;
      end
    end else if (one_hot) begin
      verdict_o.status = ST_FIXED;
    end
  end

endmodule

// File: rtl/ecc_patch_seq.sv
module ecc_patch_seq
  import ecc_fix_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  verdict_t         verdict_i,
  input  logic [IDX_W-1:0] byte_i,
  input  logic [2:0]       bit_i,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] addr_o,
  input  logic [7:0]       rdata_i,
  output logic [7:0]       wdata_o,
  output logic             done_o,
  output ecc_status_e      status_o
);

  patch_phase_e     ph_q, ph_d;
  logic [IDX_W-1:0] addr_q, addr_d;
  logic [7:0]       mask_q, mask_d;
  logic [7:0]       wdata_q, wdata_d;
  ecc_status_e      status_q, status_d;
  logic             rd_q, rd_d;
  logic             wr_q, wr_d;
  logic             done_q, done_d;
  logic             addr_en, mask_en, wdata_en, status_en;

  always_comb begin
    ph_d      = ph_q;
    rd_d      = 1'b0;
    wr_d      = 1'b0;
    done_d    = 1'b0;
    addr_en   = 1'b0;
    mask_en   = 1'b0;
    wdata_en  = 1'b0;
    status_en = 1'b0;
    addr_d    = byte_i;
    mask_d    = 8'(1) << bit_i;
    wdata_d   = rdata_i ^ mask_q;
    status_d  = verdict_i.status;
    unique case (ph_q)
      PH_IDLE: begin
        if (launch_i) begin
          if (verdict_i.patch) begin
            rd_d    = 1'b1;
            addr_en = 1'b1;
            mask_en = 1'b1;
            ph_d    = PH_READ;
          end else begin
            done_d    = 1'b1;
            status_en = 1'b1;
          end
        end
      end
      PH_READ: begin
        ph_d = PH_WRITE;
      end
      PH_WRITE: begin
        wr_d      = 1'b1;
        wdata_en  = 1'b1;
        done_d    = 1'b1;
        status_en = 1'b1;
        status_d  = ST_FIXED;
        ph_d      = PH_IDLE;
      end
      default: begin
        ph_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      mask_q   <= '0;
      wdata_q  <= '0;
      status_q <= ST_CLEAN;
    end else begin
      ph_q   <= ph_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      done_q <= done_d;
      if (addr_en)   addr_q   <= addr_d;
      if (mask_en)   mask_q   <= mask_d;
      if (wdata_en)  wdata_q  <= wdata_d;
      if (status_en) status_q <= status_d;
    end
  end

  assign rd_en_o  = rd_q;
  assign wr_en_o  = wr_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign done_o   = done_q;
  assign status_o = status_q;

  // R7: a write-back always comes two cycles after its read strobe
  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rd_en_o, 2));

  // R3: the repaired byte differs from the byte read in exactly one bit
  a_r3_single_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($countones(wdata_o ^ $past(rdata_i)) == 1));

  // R7: the address is held from the read to the write
  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (addr_o == $past(addr_o, 2)));

  // R8: no second read while a patch is in flight
  a_r8_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

endmodule

// File: rtl/hamming_chunk_corrector.sv
module hamming_chunk_corrector
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int HI_LSB      = 16,
  parameter int RAW_W       = 32,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int IDX_W  = HALF_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW_W-1:0]  raw_parity_i,
  output logic [CODE_W-1:0] packed_code_o,
  input  logic              start_i,
  input  logic [CODE_W-1:0] calc_code_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic              buf_rd_en_o,
  output logic              buf_wr_en_o,
  output logic [IDX_W-1:0]  buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic [7:0]        buf_wdata_o,
  output logic              done_o,
  output logic [1:0]        status_o
);

  verdict_t         verdict;
  logic [IDX_W-1:0] err_byte;
  logic [2:0]       err_bit;
  ecc_status_e      status_e;

  ecc_code_packer #(
    .HALF_W (HALF_W),
    .HI_LSB (HI_LSB),
    .RAW_W  (RAW_W)
  ) u_packer (
    .raw_i  (raw_parity_i),
    .code_o (packed_code_o)
  );

  ecc_diff_judge #(
    .HALF_W      (HALF_W),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_judge (
    .calc_i    (calc_code_i),
    .stored_i  (stored_code_i),
    .verdict_o (verdict),
    .byte_o    (err_byte),
    .bit_o     (err_bit)
  );

  ecc_patch_seq #(
    .IDX_W (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (start_i),
    .verdict_i (verdict),
    .byte_i    (err_byte),
    .bit_i     (err_bit),
    .rd_en_o   (buf_rd_en_o),
    .wr_en_o   (buf_wr_en_o),
    .addr_o    (buf_addr_o),
    .rdata_i   (buf_rdata_i),
    .wdata_o   (buf_wdata_o),
    .done_o    (done_o),
    .status_o  (status_e)
  );

  assign status_o = status_e;

  // R2: a clean verdict is reported in the cycle after the request
  a_r2_clean_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_CLEAN) |-> $past(start_i));

  // R4, R6: an uncorrectable verdict never comes with a write
  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_FAIL) |-> !buf_wr_en_o);

  // R5: a corrected verdict without a write answers the request of the previous cycle
  a_r5_checkbit_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_FIXED && !buf_wr_en_o) |-> $past(start_i));

  // R7: a write-back is always flagged as done with corrected status
  a_r7_write_is_done: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en_o |-> (done_o && status_o == ST_FIXED));

endmodule

// File: tb/hamming_chunk_corrector_tb.sv
module hamming_chunk_corrector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 384;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] raw;
  logic [23:0] packed_code;
  logic        start;
  logic [23:0] calc, stored;
  logic        rd_en, wr_en;
  logic [8:0]  addr;
  logic [7:0]  rdata, wdata;
  logic        done;
  logic [1:0]  status;

  logic [7:0]  buf_mem [512];
  logic [7:0]  ref_mem [512];

  int    n_run, n_fail;
  string cur_req;
  logic  checking;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_chunk_corrector #(.CHUNK_BYTES(CHUNK)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .raw_parity_i  (raw),
    .packed_code_o (packed_code),
    .start_i       (start),
    .calc_code_i   (calc),
    .stored_code_i (stored),
    .buf_rd_en_o   (rd_en),
    .buf_wr_en_o   (wr_en),
    .buf_addr_o    (addr),
    .buf_rdata_i   (rdata),
    .buf_wdata_o   (wdata),
    .done_o        (done),
    .status_o      (status)
  );

  // chunk buffer: registered read, one cycle latency
  always @(posedge clk) begin
    if (rd_en) rdata <= buf_mem[addr];
    if (wr_en) buf_mem[addr] <= wdata;
  end

  function automatic logic [7:0] seed_byte(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [23:0] fmt_model(logic [31:0] r);
    int v;
    v = ~((int'(r >> 4) & 32'h00fff000) | (int'(r) & 32'h00000fff));
    return 24'(v & 32'h00ffffff);
  endfunction

  function automatic logic [23:0] mk_corr(int idx, int bt);
    int h;
    h = (idx << 3) | bt;
    return 24'((h << 12) | (~h & 32'hfff));
  endfunction

  // 0 clean, 1 corrected quietly, 2 uncorrectable, 3 patch needed
  function automatic int classify(logic [23:0] d, output int idx, output int bt);
    int dv;
    dv  = int'(d);
    idx = dv >> 15;
    bt  = (dv >> 12) & 7;
    if (dv == 0) return 0;
    if ((((dv >> 12) ^ dv) & 32'hfff) == 32'hfff) return (idx < CHUNK) ? 3 : 2;
    if ($countones(d) == 1) return 1;
    return 2;
  endfunction

  // behavioural reference, advanced every clock
  int         m_phase, m_idx, m_bit;
  logic       e_done, e_rd, e_wr;
  logic [1:0] e_status;
  int         e_addr;
  logic [7:0] e_wdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase  <= 0;
      e_done   <= 1'b0;
      e_rd     <= 1'b0;
      e_wr     <= 1'b0;
      e_status <= 2'b00;
    end else begin : model
      int k, i, b;
      e_done <= 1'b0;
      e_rd   <= 1'b0;
      e_wr   <= 1'b0;
      if (m_phase == 2) begin
        e_wr     <= 1'b1;
        e_done   <= 1'b1;
        e_status <= 2'b01;
        e_addr   <= m_idx;
        e_wdata  <= ref_mem[m_idx] ^ 8'(1 << m_bit);
        ref_mem[m_idx] <= ref_mem[m_idx] ^ 8'(1 << m_bit);
        m_phase  <= 0;
      end else if (m_phase == 1) begin
        m_phase <= 2;
      end else if (start) begin
        k = classify(calc ^ stored, i, b);
        if (k == 3) begin
          e_rd    <= 1'b1;
          e_addr  <= i;
          m_idx   <= i;
          m_bit   <= b;
          m_phase <= 1;
        end else begin
          e_done   <= 1'b1;
          e_status <= 2'(k);
        end
      end
    end
  end

  task automatic chk(int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(int'(done), int'(e_done), "done");
      chk(int'(rd_en), int'(e_rd), "rd_en");
      chk(int'(wr_en), int'(e_wr), "wr_en");
      if (e_done) chk(int'(status), int'(e_status), "status");
      if (e_rd || e_wr) chk(int'(addr), e_addr, "addr");
      if (e_wr) chk(int'(wdata), int'(e_wdata), "wdata");
    end
  end

  task automatic job(logic [23:0] st, logic [23:0] df, string tag, int hold);
    cur_req = tag;
    stored  = st;
    calc    = st ^ df;
    start   = 1'b1;
    repeat (hold) @(negedge clk);
    start   = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    n_run    = 0;
    n_fail   = 0;
    checking = 1'b0;
    start    = 1'b0;
    calc     = '0;
    stored   = '0;
    raw      = '0;
    rst_n    = 1'b0;
    cur_req  = "R9";
    for (int i = 0; i < 512; i++) begin
      buf_mem[i] = seed_byte(i);
      ref_mem[i] = seed_byte(i);
    end
    repeat (3) @(negedge clk);
    chk(int'(done), 0, "done in reset");
    chk(int'(rd_en), 0, "rd_en in reset");
    chk(int'(wr_en), 0, "wr_en in reset");
    chk(int'(status), 0, "status in reset");
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1'b1;

    cur_req = "R1";
    raw = 32'h0000_0000; #1 chk(int'(packed_code), int'(fmt_model(raw)), "code zero");
    chk(int'(packed_code), 32'hffffff, "erased code");
    raw = 32'hffff_ffff; #1 chk(int'(packed_code), int'(fmt_model(raw)), "code ones");
    raw = 32'h1234_5678; #1 chk(int'(packed_code), int'(fmt_model(raw)), "code mix");
    raw = 32'h0abc_0def; #1 chk(int'(packed_code), int'(fmt_model(raw)), "code fields");
    @(negedge clk);

    job(24'h5a3c96, 24'h000000, "R2", 1);
    job(24'hffffff, 24'h000000, "R2", 1);

    job(24'h123456, mk_corr(0, 0), "R3", 1);
    job(24'h123456, mk_corr(10, 3), "R3", 1);
    cur_req = "R3";
    chk(int'(buf_mem[10]), int'(seed_byte(10) ^ 8'h08), "byte 10 patched");
    job(24'h00ff00, mk_corr(383, 7), "R3", 1);
    job(24'habcdef, mk_corr(200, 5), "R7", 1);

    job(24'h123456, mk_corr(384, 1), "R4", 1);
    job(24'h777777, mk_corr(511, 7), "R4", 1);

    job(24'h111111, 24'h000001, "R5", 1);
    job(24'h111111, 24'h800000, "R5", 1);
    job(24'h222222, 24'h001000, "R5", 1);

    job(24'h333333, 24'h000003, "R6", 1);
    job(24'h333333, 24'h100100, "R6", 1);
    job(24'h333333, 24'hffffff, "R6", 1);

    job(24'h456789, mk_corr(50, 2), "R8", 3);
    job(24'h456789, mk_corr(60, 6), "R8", 4);

    checking = 1'b0;
    cur_req  = "R3";
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 512; i++) if (buf_mem[i] !== ref_mem[i]) bad++;
      chk(bad, 0, "buffer mismatches");
    end
    chk(int'(buf_mem[60]), int'(seed_byte(60)), "byte 60 flipped twice");
    cur_req = "R8";
    chk(int'(buf_mem[50]), int'(seed_byte(50) ^ 8'h04), "byte 50 flipped once");
    summary();
    $finish;
  end

endmodule